// File: doc/BRIEF.md
# Serial-Flash Clock Divider and Gate

This block derives the clocks for a serial flash controller from one fast input clock. Two dividers are chained. The first, the source divider, divides by 5 or by 6. The second, the main divider, divides the source rate by 2, 4, 6 or 8. The result is the main output. A second output runs at exactly half the main rate and toggles on each rising edge of the ungated main waveform. Each output has its own disable bit, and setting that bit holds the output low.

All settings live in one 10-bit control register. Each write carries a per-bit mask, so a single cycle updates only the selected bits. Two agents can therefore change different fields without a software read-modify-write sequence that one of them could interrupt. The dividers run in the input clock domain, and both outputs come from flops clocked by that input.

Top module: `sfclk_gen`

## Requirements
- R1: After reset the register reads 0x311 (source code 2, main code 1, both disable bits set), and both outputs are low.
- R2: A write with `cfg_we` high updates each register bit whose `cfg_wmask` bit is 1 to the matching `cfg_wdata` bit and keeps every other bit. The new value is visible on `cfg_rdata` in the next cycle. Bits 7:5 always read 0.
- R3: While `cfg_we` is low, `cfg_rdata` does not change.
- R4: Register bits 4:3 hold the source code. Code 3 divides by 6, and codes 0, 1 and 2 divide by 5.
- R5: Register bits 2:0 hold the main code. Odd code k divides by k+1. Even code c acts as c+1 and divides by c+2.
- R6: When enabled, the main output is high for S*M/2 input cycles and low for S*M/2 input cycles, where S is the source divisor and M is the main divisor.
- R7: When enabled, the half-rate output is high for S*M cycles and low for S*M cycles. It changes only in a cycle in which the main waveform rises.
- R8: Register bit 8 set to 1 holds the main output low. The half-rate output keeps toggling while bit 8 is set.
- R9: Register bit 9 set to 1 holds the half-rate output low. The main output keeps toggling while bit 9 is set.
- R10: After a divisor write, once the old period has run out, the outputs follow the new divisors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wmask | input | 10 | Per-bit write enable |
| cfg_wdata | input | 10 | Write data |
| cfg_rdata | output | 10 | Current register value |
| main_clk_o | output | 1 | Main divided clock, gated by bit 8 |
| half_clk_o | output | 1 | Half-rate clock, gated by bit 9 |

## Verification
A register write can land in the same cycle in which the source counter wraps and the main waveform toggles. The write then changes the terminal counts while the counters are crossing them. The bench provokes this by issuing divisor writes at random phases relative to the outputs. After a settle interval it measures complete high and low phases and compares them with S*M/2 and S*M. The checker also asserts that, while both outputs are steadily enabled, a half-rate edge falls only on a main rising edge and no output phase is shorter than two cycles.

// File: rtl/sfclk_gen.sv
module sfclk_gen #(
  parameter int          REG_W   = 10,
  parameter logic [9:0]  RST_VAL = 10'h311
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wmask,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             main_clk_o,
  output logic             half_clk_o
);
  localparam logic [REG_W-1:0] LEGAL = 10'h31F;

  logic [REG_W-1:0] ctrl_q;
  logic [2:0]       src_cnt;
  logic [1:0]       main_cnt;
  logic             main_t, half_t;
  logic [2:0]       src_last;
  logic [1:0]       main_last;
  logic             src_tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ctrl_q <= RST_VAL & LEGAL;
    else if (cfg_we) ctrl_q <= ((ctrl_q & ~cfg_wmask) | (cfg_wdata & cfg_wmask)) & LEGAL;

  assign src_last  = (ctrl_q[4:3] == 2'd3) ? 3'd5 : 3'd4;
  assign main_last = ctrl_q[2:1];
  assign src_tick  = (src_cnt >= src_last);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      src_cnt  <= '0;
      main_cnt <= '0;
      main_t   <= 1'b0;
      half_t   <= 1'b0;
    end else begin
      src_cnt <= src_tick ? 3'd0 : src_cnt + 3'd1;
      if (src_tick) begin
        if (main_cnt >= main_last) begin
          main_cnt <= '0;
          main_t   <= ~main_t;
          if (!main_t) half_t <= ~half_t;
        end else begin
          main_cnt <= main_cnt + 2'd1;
        end
      end
    end

  assign cfg_rdata  = ctrl_q;
  assign main_clk_o = main_t & ~ctrl_q[8];
  assign half_clk_o = half_t & ~ctrl_q[9];
endmodule

// File: rtl/sfclk_gen_chk.sv
module sfclk_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we,
  input logic [9:0] cfg_wmask,
  input logic [9:0] cfg_wdata,
  input logic [9:0] cfg_rdata,
  input logic       main_clk_o,
  input logic       half_clk_o
);
  logic steady_on;
  assign steady_on = !cfg_we && !cfg_rdata[8] && !cfg_rdata[9];

  assert_masked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we |=> cfg_rdata == ((($past(cfg_rdata) & ~$past(cfg_wmask)) |
                              ($past(cfg_wdata) & $past(cfg_wmask))) & 10'h31F));

  assert_hold_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we |=> $stable(cfg_rdata));

  assert_half_on_main_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady_on && $past(steady_on) && !$stable(half_clk_o)) |-> $rose(main_clk_o));

  assert_main_min_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady_on && $past(steady_on) && !$stable(main_clk_o)) |=> (cfg_we || cfg_rdata[8] || $stable(main_clk_o)));

  assert_half_min_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady_on && $past(steady_on) && !$stable(half_clk_o)) |=> (cfg_we || cfg_rdata[9] || $stable(half_clk_o)));
endmodule

bind sfclk_gen sfclk_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we(cfg_we), .cfg_wmask(cfg_wmask),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .main_clk_o(main_clk_o),
  .half_clk_o(half_clk_o)
);

// File: tb/sim_sfclk_gen.sv
`timescale 1ns/1ps
module sim_sfclk_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wmask = '0, cfg_wdata = '0;
  logic [9:0] cfg_rdata;
  logic       main_clk_o, half_clk_o;

  int n_chk = 0, n_bad = 0;
  logic [9:0] mreg;

  always #2 clk_i = ~clk_i;

  sfclk_gen u0 (.*);

  function automatic int src_div(input logic [1:0] c);
    return (c == 2'd3) ? 6 : 5;
  endfunction

  function automatic int main_div(input logic [2:0] c);
    return c[0] ? int'(c) + 1 : int'(c) + 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] m, input logic [9:0] d);
    @(negedge clk_i);
    cfg_we = 1'b1; cfg_wmask = m; cfg_wdata = d;
    @(negedge clk_i);
    cfg_we = 1'b0;
    mreg = ((mreg & ~m) | (d & m)) & 10'h31F;
  endtask

  function automatic logic pick(input bit half);
    return half ? half_clk_o : main_clk_o;
  endfunction

  task automatic measure(input bit half, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (pick(half) !== 1'b0 && guard < 400) begin @(negedge clk_i); guard++; end
    while (pick(half) !== 1'b1 && guard < 400) begin @(negedge clk_i); guard++; end
    while (pick(half) === 1'b1 && guard < 400) begin hi++; @(negedge clk_i); guard++; end
    while (pick(half) === 1'b0 && guard < 400) begin lo++; @(negedge clk_i); guard++; end
  endtask

  task automatic run_cfg(input logic [1:0] sc, input logic [2:0] mc);
    int hi, lo, p;
    wr(10'h01F, {5'b0, sc, mc});
    repeat (200) @(negedge clk_i);
    p = src_div(sc) * main_div(mc);
    measure(1'b0, hi, lo);
    check("R4/R5/R6/R10 main high", hi, p / 2);
    check("R6 main low", lo, p / 2);
    measure(1'b1, hi, lo);
    check("R7 half high", hi, p);
    check("R7 half low", lo, p);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int toggles;
    logic prev;
    void'($urandom(32'd2718));
    mreg = 10'h311;
    repeat (3) @(negedge clk_i);
    check("R1 reset main low", main_clk_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 reset value", cfg_rdata, 10'h311);
    check("R1 main low", main_clk_o, 0);
    check("R1 half low", half_clk_o, 0);

    wr(10'h0E0, 10'h0E0);
    check("R2 bits 7:5 read zero", cfg_rdata, mreg);
    wr(10'h300, 10'h000);
    check("R2 masked enable write", cfg_rdata, mreg);
    repeat (20) @(negedge clk_i);
    check("R3 stable without write", cfg_rdata, mreg);

    run_cfg(2'd3, 3'd7);
    run_cfg(2'd0, 3'd0);
    run_cfg(2'd2, 3'd6);
    for (int i = 0; i < 10; i++) begin
      logic [9:0] m, d;
      run_cfg(2'($urandom_range(3)), 3'($urandom_range(7)));
      m = 10'($urandom) & 10'h01F;
      d = 10'($urandom);
      wr(m, d);
      check("R2 random masked write", cfg_rdata, mreg);
      check("R2 enables untouched", {30'b0, cfg_rdata[9:8]}, 0);
    end

    run_cfg(2'd1, 3'd1);
    wr(10'h100, 10'h100);
    toggles = 0; prev = half_clk_o;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (main_clk_o !== 1'b0) toggles += 1000;
      if (half_clk_o !== prev) toggles++;
      prev = half_clk_o;
    end
    check("R8 main held low", toggles >= 1000, 0);
    check("R8 half keeps toggling", toggles > 0, 1);

    wr(10'h300, 10'h200);
    toggles = 0; prev = main_clk_o;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (half_clk_o !== 1'b0) toggles += 1000;
      if (main_clk_o !== prev) toggles++;
      prev = main_clk_o;
    end
    check("R9 half held low", toggles >= 1000, 0);
    check("R9 main keeps toggling", toggles > 0, 1);
    check("R2 readback after gates", cfg_rdata, mreg);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule